// File: doc/BRIEF.md
# Frame-Paced Periodic Interrupt and Watchdog Timer

This block is the timer unit of a telephone-terminal controller. It counts the 8 kHz frame-synchronisation ticks, which arrive as one-cycle pulses on `frameTick`. Every `IRQ_PERIOD` ticks (64 by default, which is 8 ms) it pulls the active-low interrupt line low. The line stays low until the processor sends a release pulse. The interval counter runs on a fixed grid that starts at reset. A release arriving part-way through an interval does not move the grid. When no frame ticks arrive, the counter stops, so no interrupts are raised.

A watchdog runs from the same ticks. If `WD_PERIOD` ticks (4000 by default, which is 500 ms) pass without a restart pulse, it raises a timeout flag. The flag stays set until the next reset. Bus decoding and detection of a missing frame clock are handled elsewhere.

Top module: `frame_irq_wdt`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `irqN` is 1 and `wdTimeout` is 0.
- R2: After reset is released, `irqN` first goes to 0 in the cycle that follows the `IRQ_PERIOD`-th cycle in which `frameTick` is 1. It is not 0 any earlier.
- R3: Once `irqN` is 0 it stays 0 until `irqRelease` is 1 in a cycle. In the following cycle `irqN` is 1, provided no period ended in the release cycle.
- R4: If a release and the end of a period fall in the same cycle, the assertion wins and `irqN` stays 0.
- R5: A release does not reset the interval count. The next assertion comes at the next multiple of `IRQ_PERIOD` ticks counted from reset.
- R6: Cycles in which `frameTick` is 0 do not advance the interval. With no ticks, `irqN` never falls.
- R7: If periods end while `irqN` is already 0 and no release arrives, `irqN` stays 0.
- R8: If `wdRestart` stays 0, `wdTimeout` goes to 1 in the cycle after the `WD_PERIOD`-th tick counted from reset or from the last restart.
- R9: A `wdRestart` pulse sets the watchdog count back to zero. A restart in the same cycle as the final tick prevents the timeout.
- R10: Once `wdTimeout` is 1 it stays 1 until reset, whatever `wdRestart` does.
- R11: A reset in the middle of operation brings both outputs back to their reset values and restarts both counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-cycle pulse per frame sync |
| irqRelease | input | 1 | Interrupt release pulse from the processor |
| wdRestart | input | 1 | Watchdog restart pulse from the register write |
| irqN | output | 1 | Active-low latched periodic interrupt |
| wdTimeout | output | 1 | Sticky watchdog timeout flag |

## Verification
The hardest cases to reach from the ports are the exact coincidences. One is a release in the very cycle that ends a period. The other is a restart in the very cycle of the last watchdog tick. The bench runs with short periods and keeps its own count of ticks since reset and since the last restart. It uses those counts to place these pulses on the exact cycle. It also sweeps the release over every offset inside an interval to show that the grid does not move.

// File: rtl/frame_irq_wdt_pkg.sv
package frame_irq_wdt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic intervalAdvance;
    logic intervalWrap;
    logic wdAdvance;
    logic wdClear;
  } ctrlStrobes_t;

  // Status from datapath to control
  typedef struct packed {
    logic intervalLast;
    logic wdLast;
  } cntStatus_t;

endpackage

// File: rtl/frame_irq_wdt_datapath.sv
module frame_irq_wdt_datapath
  import frame_irq_wdt_pkg::*;
#(
  parameter int IRQ_PERIOD = 64,
  parameter int WD_PERIOD  = 4000
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output cntStatus_t   status
);
  localparam int IW = (IRQ_PERIOD > 1) ? $clog2(IRQ_PERIOD) : 1;
  localparam int WW = (WD_PERIOD > 1) ? $clog2(WD_PERIOD) : 1;
  localparam logic [IW-1:0] INT_LAST = IW'(IRQ_PERIOD - 1);
  localparam logic [WW-1:0] WD_LAST  = WW'(WD_PERIOD - 1);

  logic [IW-1:0] intervalCnt;
  logic [WW-1:0] wdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (strobes.intervalWrap) begin
      intervalCnt <= '0;
    end else if (strobes.intervalAdvance) begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (strobes.wdClear) begin
      wdCnt <= '0;
    end else if (strobes.wdAdvance && (wdCnt != WD_LAST)) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  always_comb begin
    status.intervalLast = (intervalCnt == INT_LAST);
    status.wdLast       = (wdCnt == WD_LAST);
  end

  // Interval count holds when no tick is present
  assert_interval_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.intervalAdvance |=> $stable(intervalCnt));

  // Interval count never leaves its range, so the grid is fixed
  assert_interval_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    intervalCnt <= INT_LAST);

  // Restart clears the watchdog count
  assert_wd_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wdClear |=> (wdCnt == '0));

endmodule

// File: rtl/frame_irq_wdt_control.sv
module frame_irq_wdt_control
  import frame_irq_wdt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameTick,
  input  logic         irqRelease,
  input  logic         wdRestart,
  input  cntStatus_t   status,
  output ctrlStrobes_t strobes,
  output logic         irqActive,
  output logic         timeoutFlag
);
  logic periodEnd;
  logic wdExpire;

  always_comb begin
    periodEnd               = frameTick && status.intervalLast;
    wdExpire                = frameTick && !wdRestart && !timeoutFlag && status.wdLast;
    strobes.intervalAdvance = frameTick;
    strobes.intervalWrap    = periodEnd;
    strobes.wdClear         = wdRestart;
    strobes.wdAdvance       = frameTick && !wdRestart && !timeoutFlag;
  end

  // Assertion has priority over release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqActive <= 1'b0;
    end else if (periodEnd) begin
      irqActive <= 1'b1;
    end else if (irqRelease) begin
      irqActive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
    end else if (wdExpire) begin
      timeoutFlag <= 1'b1;
    end
  end

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqActive && !irqRelease |=> irqActive);

  assert_irq_needs_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqActive) |-> $past(frameTick));

  assert_release_loses_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameTick && status.intervalLast && irqRelease |=> irqActive);

  assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |=> timeoutFlag);

  assert_timeout_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> ($past(frameTick) && !$past(wdRestart)));

endmodule

// File: rtl/frame_irq_wdt.sv
module frame_irq_wdt
  import frame_irq_wdt_pkg::*;
#(
  parameter int IRQ_PERIOD = 64,
  parameter int WD_PERIOD  = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameTick,
  input  logic irqRelease,
  input  logic wdRestart,
  output logic irqN,
  output logic wdTimeout
);
  ctrlStrobes_t strobes;
  cntStatus_t   status;
  logic         irqActive;
  logic         timeoutFlag;

  frame_irq_wdt_control control_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameTick  (frameTick),
    .irqRelease (irqRelease),
    .wdRestart  (wdRestart),
    .status     (status),
    .strobes    (strobes),
    .irqActive  (irqActive),
    .timeoutFlag(timeoutFlag)
  );

  frame_irq_wdt_datapath #(
    .IRQ_PERIOD(IRQ_PERIOD),
    .WD_PERIOD (WD_PERIOD)
  ) datapath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .status (status)
  );

  assign irqN      = !irqActive;
  assign wdTimeout = timeoutFlag;

  // Reset state at the ports
  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |-> (irqN && !wdTimeout));

endmodule

// File: tb/frame_irq_wdt_tb.sv
module frame_irq_wdt_tb_top;
  localparam int P = 4;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b0;
  logic irqRelease = 1'b0;
  logic wdRestart = 1'b0;
  logic irqN;
  logic wdTimeout;

  int checks = 0;
  int fails = 0;

  // model state
  int  mInt = 0;
  int  mWdCnt = 0;
  bit  mIrq = 0;
  bit  mWd = 0;

  always #2.5 clk = ~clk;

  frame_irq_wdt #(.IRQ_PERIOD(P), .WD_PERIOD(W)) dut_i (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .irqRelease(irqRelease),
    .wdRestart(wdRestart), .irqN(irqN), .wdTimeout(wdTimeout)
  );

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic checkOuts(input string tag);
    check(tag, "irqN", irqN, !mIrq);
    check(tag, "wdTimeout", wdTimeout, mWd);
  endtask

  // One clock cycle with the given inputs; checks the outputs afterwards
  task automatic cyc(input bit t, input bit r, input bit w, input string tag);
    bit fire;
    frameTick = t; irqRelease = r; wdRestart = w;
    @(posedge clk);
    fire = 0;
    if (t) begin
      if (mInt == P - 1) begin mInt = 0; fire = 1; end
      else mInt++;
    end
    if (fire) mIrq = 1;
    else if (r) mIrq = 0;
    if (w) mWdCnt = 0;
    else if (t && !mWd) begin
      if (mWdCnt == W - 1) mWd = 1;
      else mWdCnt++;
    end
    @(negedge clk);
    frameTick = 0; irqRelease = 0; wdRestart = 0;
    checkOuts(tag);
  endtask

  task automatic doReset(input string tag);
    rstN = 0;
    mInt = 0; mWdCnt = 0; mIrq = 0; mWd = 0;
    repeat (3) @(negedge clk);
    checkOuts(tag);
    rstN = 1;
    cyc(0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    checkOuts("R1");
    doReset("R1");

    // R6: idle cycles without ticks never raise the interrupt
    for (int i = 0; i < 12; i++) cyc(0, 0, (i % 4 == 0), "R6");

    // R2: first assertion exactly after P ticks, gaps between ticks
    for (int i = 0; i < P; i++) begin
      cyc(1, 0, 1, "R2");
      cyc(0, 0, 0, "R2");
    end
    check("R2", "irqN after first period", irqN, 1'b0);

    // R7: further periods without release keep it low
    for (int i = 0; i < 2 * P; i++) cyc(1, 0, (i % 3 == 0), "R7");

    // R3: release raises the line
    cyc(0, 1, 0, "R3");
    check("R3", "irqN after release", irqN, 1'b1);

    // R5: sweep release offset across the interval; grid stays fixed
    for (int off = 0; off < P; off++) begin
      while (mIrq == 0) cyc(1, 0, 1, "R5");
      for (int k = 0; k < off; k++) cyc(1, 0, 1, "R5");
      cyc(0, 1, 1, "R5");
      for (int k = 0; k < P; k++) cyc(1, 0, 1, "R5");
    end

    // R4: release on the same tick as period end
    for (int rep = 0; rep < 3; rep++) begin
      while (mInt != P - 1) cyc(1, 0, 1, "R4");
      cyc(1, 1, 1, "R4");
      check("R4", "irqN on coincident release", irqN, 1'b0);
      cyc(0, 1, 1, "R3");
    end

    // R9: periodic restarts prevent timeout, restart on last tick too
    for (int i = 0; i < 3 * W; i++) cyc(1, (i % 2 == 0), (i % 5 == 4), "R9");
    cyc(0, 0, 1, "R9");
    for (int i = 0; i < W - 1; i++) cyc(1, 0, 0, "R9");
    cyc(1, 0, 1, "R9");
    check("R9", "wdTimeout after restart on last tick", wdTimeout, 1'b0);

    // R8: W ticks without restart
    for (int i = 0; i < W - 1; i++) cyc(1, 0, 0, "R8");
    check("R8", "wdTimeout one tick early", wdTimeout, 1'b0);
    cyc(1, 0, 0, "R8");
    check("R8", "wdTimeout at limit", wdTimeout, 1'b1);

    // R10: sticky despite restarts
    for (int i = 0; i < 2 * W; i++) cyc((i % 2 == 0), 0, 1, "R10");
    check("R10", "wdTimeout after restarts", wdTimeout, 1'b1);

    // R11: reset mid-run with irq low and timeout set
    while (mIrq == 0) cyc(1, 0, 0, "R11");
    cyc(1, 0, 0, "R11");
    doReset("R11");
    for (int i = 0; i < P - 1; i++) cyc(1, 0, 0, "R11");
    check("R11", "irqN before first period after reset", irqN, 1'b1);
    cyc(1, 0, 0, "R11");
    check("R11", "irqN at first period after reset", irqN, 1'b0);
    for (int i = 0; i < W - P; i++) cyc(1, 1, 0, "R11");
    check("R11", "wdTimeout after W ticks", wdTimeout, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule